// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Controller

This block collects single-cycle event pulses from the transmit and receive sides of a DMA engine and holds each one in a sticky bit of a 17-bit status word. Host software reads the status word and clears the bits it has handled by writing ones to them. An enable word uses the same bit layout. It selects which latched events count toward the two summary bits and which summaries may raise the interrupt line.

Events fall into two groups. Completion events (transmit done, receive done, early receive) feed the normal summary at bit 16. Error and resource events feed the abnormal summary at bit 15. The transmit-stopped and receive-stopped events are latched but belong to neither group. The single interrupt output is a register. It combines each summary with that summary's own enable bit.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the status word, the enable word and the interrupt output are all zero.
- R2: A high pulse on an event input at an event-capable position sets that status bit after the next clock edge. The bit then holds until it is cleared. The event-capable positions are bits 0 to 10, 13 and 14.
- R3: A status write with a 1 in a bit position clears that latched bit. A 0 in a bit position leaves that bit unchanged.
- R4: If an event and a write-1 clear reach the same bit in the same cycle, the event wins and the bit reads 1 afterwards.
- R5: Bits 11 and 12 read 0 in both the status word and the enable word. Event inputs at bits 11, 12, 15 and 16 have no effect.
- R6: Status bit 16, the normal summary, reads 1 exactly when at least one of status bits 0, 6 and 14 is set and also enabled.
- R7: Status bit 15, the abnormal summary, reads 1 exactly when at least one of status bits 2, 3, 4, 5, 7, 9, 10 and 13 is set and also enabled.
- R8: Status bits 1 and 8 latch and clear like the other event bits, but they never set either summary bit.
- R9: The interrupt output is a register. It equals (enable bit 16 AND status bit 16) OR (enable bit 15 AND status bit 15), using the values from the previous cycle.
- R10: Writing ones to status bits 15 and 16 has no effect. The summaries follow their groups only.
- R11: A write to the enable word replaces every writable enable bit with the written data, and the new value reads back after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 17 | Event pulses, one per status bit position |
| wr_status | input | 1 | Write strobe for the status word (write-1-to-clear) |
| wr_enable | input | 1 | Write strobe for the enable word |
| wr_data | input | 17 | Data for either write |
| status_o | output | 17 | Status word, including both summary bits |
| enable_o | output | 17 | Enable word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The effect of an event, a clear or an enable write shows on the status and enable words one clock edge after it is applied. The summary bits are derived from those registers without any further delay, so they move on the same edge. The interrupt output lags the summaries by one more edge. The bench applies each stimulus half a period before a rising edge and samples half a period after it. For that reason, every expected interrupt value in the vector table is worked out from the state that existed before the stimulus, not from the state it produces.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [16:0] evt_i,
  input  logic        wr_status,
  input  logic        wr_enable,
  input  logic [16:0] wr_data,
  output logic [16:0] status_o,
  output logic [16:0] enable_o,
  output logic        irq_o
);

  localparam logic [16:0] EVT_BITS = 17'h067FF;
  localparam logic [16:0] EN_BITS  = 17'h1E7FF;
  localparam logic [16:0] NRM_GRP  = 17'h04041;
  localparam logic [16:0] ABN_GRP  = 17'h026BC;
  localparam int          ABN_POS  = 15;
  localparam int          NRM_POS  = 16;

  logic [16:0] latched_q;
  logic [16:0] en_q;
  logic [16:0] clr_mask;
  logic        nrm_sum, abn_sum;
  logic        irq_q;

  assign clr_mask = wr_status ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) latched_q <= '0;
    else        latched_q <= ((latched_q & ~clr_mask) | evt_i) & EVT_BITS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= wr_data & EN_BITS;
  end

  assign nrm_sum = |(latched_q & en_q & NRM_GRP);
  assign abn_sum = |(latched_q & en_q & ABN_GRP);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (en_q[NRM_POS] & nrm_sum) | (en_q[ABN_POS] & abn_sum);
  end

  assign status_o = latched_q | ({17{nrm_sum}} & (17'h1 << NRM_POS))
                              | ({17{abn_sum}} & (17'h1 << ABN_POS));
  assign enable_o = en_q;
  assign irq_o    = irq_q;

endmodule

module dma_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [16:0] evt_i,
  input logic        wr_status,
  input logic [16:0] wr_data,
  input logic [16:0] status_o,
  input logic [16:0] enable_o,
  input logic        irq_o
);
  localparam logic [16:0] EVT_BITS = 17'h067FF;
  localparam logic [16:0] NRM_GRP  = 17'h04041;
  localparam logic [16:0] ABN_GRP  = 17'h026BC;

  assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(evt_i & EVT_BITS)) == $past(evt_i & EVT_BITS)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ((($past(status_o) & EVT_BITS) & ~status_o) == '0));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[12:11] == 2'b00) && (enable_o[12:11] == 2'b00));

  assert_normal_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[16] == (|(status_o & enable_o & NRM_GRP)));

  assert_abnormal_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15] == (|(status_o & enable_o & ABN_GRP)));

  assert_irq_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past((enable_o[16] & status_o[16]) | (enable_o[15] & status_o[15])));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_status(wr_status),
  .wr_data(wr_data), .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o)
);

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [16:0] ev;
    logic        ws;
    logic        we;
    logic [16:0] d;
    logic [16:0] xs;
    logic [16:0] xe;
    logic        xi;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{17'h00000, 1'b0, 1'b1, 17'h1FFFF, 17'h00000, 17'h1E7FF, 1'b0, 4'd11}, // R11 enable write
    '{17'h00001, 1'b0, 1'b0, 17'h00000, 17'h10001, 17'h1E7FF, 1'b0, 4'd6},  // R6 tx done
    '{17'h00000, 1'b0, 1'b0, 17'h00000, 17'h10001, 17'h1E7FF, 1'b1, 4'd9},  // R9 irq lag
    '{17'h00000, 1'b1, 1'b0, 17'h00001, 17'h00000, 17'h1E7FF, 1'b1, 4'd3},  // R3 clear
    '{17'h00000, 1'b0, 1'b0, 17'h00000, 17'h00000, 17'h1E7FF, 1'b0, 4'd9},
    '{17'h00020, 1'b0, 1'b0, 17'h00000, 17'h08020, 17'h1E7FF, 1'b0, 4'd7},  // R7 underflow
    '{17'h00002, 1'b1, 1'b0, 17'h00000, 17'h08022, 17'h1E7FF, 1'b1, 4'd3},  // R3 zero write
    '{17'h00000, 1'b1, 1'b0, 17'h00020, 17'h00002, 17'h1E7FF, 1'b1, 4'd8},  // R8 stopped alone
    '{17'h00000, 1'b0, 1'b0, 17'h00000, 17'h00002, 17'h1E7FF, 1'b0, 4'd8},
    '{17'h19800, 1'b0, 1'b0, 17'h00000, 17'h00002, 17'h1E7FF, 1'b0, 4'd5},  // R5 ignored inputs
    '{17'h00040, 1'b1, 1'b0, 17'h1FFFF, 17'h10040, 17'h1E7FF, 1'b0, 4'd4},  // R4 event beats clear
    '{17'h00000, 1'b0, 1'b1, 17'h0FFFF, 17'h10040, 17'h0E7FF, 1'b1, 4'd9},  // R9 summary enable off
    '{17'h00000, 1'b0, 1'b0, 17'h00000, 17'h10040, 17'h0E7FF, 1'b0, 4'd9},
    '{17'h00000, 1'b0, 1'b1, 17'h1E7BF, 17'h00040, 17'h1E7BF, 1'b0, 4'd6},  // R6 source disabled
    '{17'h02000, 1'b1, 1'b0, 17'h18000, 17'h0A040, 17'h1E7BF, 1'b0, 4'd10}, // R10 summary write
    '{17'h00000, 1'b0, 1'b0, 17'h00000, 17'h0A040, 17'h1E7BF, 1'b1, 4'd7},
    '{17'h00200, 1'b1, 1'b0, 17'h02200, 17'h08240, 17'h1E7BF, 1'b1, 4'd4}   // R4 same-bit race
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] evt_i = '0;
  logic        wr_status = 1'b0;
  logic        wr_enable = 1'b0;
  logic [16:0] wr_data = '0;
  logic [16:0] status_o, enable_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_ctrl i_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_status(wr_status),
    .wr_enable(wr_enable), .wr_data(wr_data),
    .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [16:0] ev, input logic ws, input logic we, input logic [16:0] d);
    evt_i = ev; wr_status = ws; wr_enable = we; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; wr_status = 1'b0; wr_enable = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", status_o, '0);
    check("R1 enable", enable_o, '0);
    check("R1 irq", {16'h0, irq_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ev, TBL[i].ws, TBL[i].we, TBL[i].d);
      check($sformatf("R%0d status row %0d", TBL[i].req, i), status_o, TBL[i].xs);
      check($sformatf("R%0d enable row %0d", TBL[i].req, i), enable_o, TBL[i].xe);
      check($sformatf("R%0d irq row %0d", TBL[i].req, i), {16'h0, irq_o}, {16'h0, TBL[i].xi});
    end
    // R5: enable write of reserved bits only
    step('0, 1'b0, 1'b1, 17'h01800);
    check("R5 enable reserved", enable_o, '0);
    // R2: fatal bus error stays set with no write
    step(17'h02000, 1'b0, 1'b0, '0);
    repeat (3) step('0, 1'b0, 1'b0, '0);
    check("R2 sticky", status_o & 17'h02000, 17'h02000);
    // R1: reset mid-run clears everything
    step('0, 1'b0, 1'b1, 17'h1FFFF);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 status after reset", status_o, '0);
    check("R1 enable after reset", enable_o, '0);
    check("R1 irq after reset", {16'h0, irq_o}, '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule